// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address for a system with 4 KB pages. It walks a two-level page table held in ordinary memory. A request carries the virtual address, a write flag and a user-mode flag. The top 10 address bits pick an entry of the top-level table, which sits at the frame named by the table-base input. That entry names the frame of a second-level table. The next 10 bits pick the final entry there. The low 12 bits pass through unchanged as the page offset.

The final entry is checked for presence and permission. A good access sets the entry's referenced flag, and a write also sets its dirty flag. The entry goes back to memory only when one of these flags actually changed. The response returns either the translated address together with the entry's cache-disable flag, or a fault with a cause code that tells an absent page apart from a permission violation.

Only one translation is in progress at a time. Both the request side and the response side use a valid/ready handshake. The memory port holds each access until the memory acknowledges it; read data is taken in the acknowledge cycle.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read from word address {tbl_base, vaddr[31:22], 2'b00}. The second-level entry is read from {top entry[31:12], vaddr[21:12], 2'b00}. A memory access holds its address, write flag and data until mem_ack.
- R2: On success the response address is {final entry[31:12], vaddr[11:0]}, with rsp_fault low and rsp_cause 0.
- R3: If bit 0 (present) of the top-level entry is clear, or if it is clear in the final entry, the response has rsp_fault high and rsp_cause 1 (absent). An absent top-level entry ends the walk after exactly one memory access.
- R4: A present final entry raises rsp_cause 2 (protection) with rsp_fault high when a write meets bit 1 (writable) clear, or when a user access meets bit 2 (user) clear.
- R5: A faulting translation performs no memory write, and the stored entry is left unchanged.
- R6: A successful access sets bit 3 (referenced), and a successful write also sets bit 4 (dirty). The entry is written back to its own address only if one of those bits changed; otherwise no write takes place.
- R7: rsp_nocache equals bit 5 (cache-disable) of the final entry on success, and is 0 on a fault.
- R8: req_ready is high only while no translation is in flight. A response stays valid, with stable contents, until rsp_ready is seen.
- R9: After reset, req_ready is high, and rsp_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 protection |
| rsp_nocache | output | 1 | Cache-disable flag of the page |

## Verification
The permission check and the referenced/dirty update both act on the same fetched final entry in a single cycle, so they can meet. A write to a present, read-only page whose referenced flag is clear would both fault and, by the update rule, need a writeback. The bench builds such entries and judges the result at the ports: the protection cause must appear, the memory write counter must not move, and the stored word must be unchanged. It also covers the opposite case, where a successful write sets dirty on an already referenced entry and exactly one write carrying the expected word must occur.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    parameter int VA_W    = 32;
    parameter int OFF_W   = 12;
    parameter int IDX_W   = 10;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int CAUSE_W = 2;

    // entry field positions
    localparam int PTE_V  = 0;
    localparam int PTE_W  = 1;
    localparam int PTE_U  = 2;
    localparam int PTE_R  = 3;
    localparam int PTE_D  = 4;
    localparam int PTE_CD = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_WB,
        ST_RESP
    } walk_state_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PROT   = 2'd2
    } fault_cause_e;

    typedef struct packed {
        walk_state_e        state;
        logic [VA_W-1:0]    vaddr;
        logic               write;
        logic               user;
        logic [FRAME_W-1:0] inner_frame;
        logic [VA_W-1:0]    entry;
        fault_cause_e       cause;
        logic               fault;
        logic [VA_W-1:0]    paddr;
        logic               nocache;
    } walk_regs_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_walker_pkg::*;
(
    input  logic [FRAME_W-1:0] base_frame,
    input  logic [IDX_W-1:0]   index,
    output logic [VA_W-1:0]    entry_addr
);
    localparam int PAD_W = VA_W - FRAME_W - IDX_W;

    always_comb begin
        entry_addr = {base_frame, index, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            is_write,
    input  logic            is_user,
    output fault_cause_e    cause,
    output logic [VA_W-1:0] new_entry,
    output logic            need_wb
);
    logic prot_bad;

    always_comb begin
        prot_bad  = (is_write && !entry[PTE_W]) || (is_user && !entry[PTE_U]);
        new_entry = entry;
        new_entry[PTE_R] = 1'b1;
        if (is_write) begin
            new_entry[PTE_D] = 1'b1;
        end
        if (!entry[PTE_V]) begin
            cause = CAUSE_ABSENT;
        end else if (prot_bad) begin
            cause = CAUSE_PROT;
        end else begin
            cause = CAUSE_NONE;
        end
        need_wb = (cause == CAUSE_NONE) && (new_entry != entry);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    input  logic               mem_ack,
    input  logic [VA_W-1:0]    mem_rdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic               rsp_nocache
);
    localparam int OUT_LSB = OFF_W + IDX_W;

    walk_regs_t   r_q, r_d;
    logic [VA_W-1:0] outer_addr, inner_addr;
    fault_cause_e chk_cause;
    logic [VA_W-1:0] chk_entry;
    logic         chk_wb;

    pt_addr_gen u_outer_addr (
        .base_frame (tbl_base),
        .index      (r_q.vaddr[VA_W-1:OUT_LSB]),
        .entry_addr (outer_addr)
    );

    pt_addr_gen u_inner_addr (
        .base_frame (r_q.inner_frame),
        .index      (r_q.vaddr[OUT_LSB-1:OFF_W]),
        .entry_addr (inner_addr)
    );

    pt_entry_check u_check (
        .entry     (mem_rdata),
        .is_write  (r_q.write),
        .is_user   (r_q.user),
        .cause     (chk_cause),
        .new_entry (chk_entry),
        .need_wb   (chk_wb)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr   = req_vaddr;
                    r_d.write   = req_write;
                    r_d.user    = req_user;
                    r_d.cause   = CAUSE_NONE;
                    r_d.fault   = 1'b0;
                    r_d.paddr   = '0;
                    r_d.nocache = 1'b0;
                    r_d.state   = ST_OUTER;
                end
            end
            ST_OUTER: begin
                mem_req  = 1'b1;
                mem_addr = outer_addr;
                if (mem_ack) begin
                    if (!mem_rdata[PTE_V]) begin
                        r_d.cause = CAUSE_ABSENT;
                        r_d.fault = 1'b1;
                        r_d.state = ST_RESP;
                    end else begin
                        r_d.inner_frame = mem_rdata[VA_W-1:OFF_W];
                        r_d.state       = ST_INNER;
                    end
                end
            end
            ST_INNER: begin
                mem_req  = 1'b1;
                mem_addr = inner_addr;
                if (mem_ack) begin
                    r_d.cause = chk_cause;
                    r_d.entry = chk_entry;
                    if (chk_cause == CAUSE_NONE) begin
                        r_d.fault   = 1'b0;
                        r_d.paddr   = {mem_rdata[VA_W-1:OFF_W], r_q.vaddr[OFF_W-1:0]};
                        r_d.nocache = mem_rdata[PTE_CD];
                        r_d.state   = chk_wb ? ST_WB : ST_RESP;
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.state = ST_RESP;
                    end
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = inner_addr;
                mem_wdata = r_q.entry;
                if (mem_ack) begin
                    r_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cause <= CAUSE_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign rsp_valid   = (r_q.state == ST_RESP);
    assign rsp_paddr   = r_q.paddr;
    assign rsp_fault   = r_q.fault;
    assign rsp_cause   = r_q.cause;
    assign rsp_nocache = r_q.nocache;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req)); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_cause) && $stable(rsp_nocache))); // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata))); // R1

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0))); // R3

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_nocache)); // R7

    AST_WB_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (rsp_cause == 2'd0 && mem_wdata[PTE_R] && mem_wdata[PTE_V])); // R5

    AST_WB_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && r_q.write) |-> mem_wdata[PTE_D]); // R6
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] tbl_base = 20'h00001;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        rsp_nocache;

    int checks = 0;
    int fails = 0;
    int acc_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] last_wr_addr;
    logic [31:0] first_rd_addr, second_rd_addr;
    logic [31:0] got_paddr;
    logic [1:0]  got_cause;
    logic        got_fault, got_nc;

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_nocache(rsp_nocache)
    );

    // memory model: acknowledges every access after one idle cycle
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            acc_cnt = acc_cnt + 1;
            if (acc_cnt == 1) first_rd_addr = mem_addr;
            if (acc_cnt == 2) second_rd_addr = mem_addr;
            if (mem_we) begin
                mem[mem_addr[13:2]] = mem_wdata;
                wr_cnt = wr_cnt + 1;
                last_wr_addr = mem_addr;
            end else begin
                mem_rdata = mem[mem_addr[13:2]];
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one translation; hold cycles keep rsp_ready low to test backpressure
    task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input int hold);
        acc_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_paddr = rsp_paddr;
        got_cause = rsp_cause;
        got_fault = rsp_fault;
        got_nc    = rsp_nocache;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R8 held valid", {31'd0, rsp_valid}, 32'd1);
            chk("R8 held paddr", rsp_paddr, got_paddr);
            chk("R8 ready low in flight", {31'd0, req_ready}, 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] va_of(input int o, input int i, input int off);
        return (32'(o) << 22) | (32'(i) << 12) | 32'(off);
    endfunction

    task automatic t_reset();
        chk("R9 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9 mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_read_ok();
        int w0 = wr_cnt;
        walk(va_of(0, 0, 12'h5A4), 1'b0, 1'b1, 0);
        chk("R1 outer addr", first_rd_addr, 32'h0000_1000);
        chk("R1 inner addr", second_rd_addr, 32'h0000_2000);
        chk("R2 paddr", got_paddr, 32'hABCD_E5A4);
        chk("R2 cause", {30'd0, got_cause}, 32'd0);
        chk("R6 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R6 wb addr", last_wr_addr, 32'h0000_2000);
        chk("R6 ref set", mem[12'd2048], 32'hABCD_E00F);
    endtask

    task automatic t_read_no_change();
        int w0 = wr_cnt;
        walk(va_of(0, 1, 12'h010), 1'b0, 1'b1, 3);
        chk("R2 paddr ro", got_paddr, 32'h1234_5010);
        chk("R6 no write when unchanged", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_write_dirty();
        int w0 = wr_cnt;
        walk(va_of(0, 4, 12'hFFC), 1'b1, 1'b1, 0);
        chk("R2 paddr wr", got_paddr, 32'h0F0F_0FFC);
        chk("R6 dirty write", 32'(wr_cnt - w0), 32'd1);
        chk("R6 dirty set", mem[12'd2052], 32'h0F0F_001F);
        w0 = wr_cnt;
        walk(va_of(1, 5, 12'h008), 1'b1, 1'b0, 0);
        chk("R1 second table paddr", got_paddr, 32'h7777_7008);
        chk("R6 already dirty no write", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_absent();
        int w0 = wr_cnt;
        walk(va_of(2, 0, 0), 1'b0, 1'b0, 0);
        chk("R3 outer absent cause", {30'd0, got_cause}, 32'd1);
        chk("R3 outer absent fault", {31'd0, got_fault}, 32'd1);
        chk("R3 one access", 32'(acc_cnt), 32'd1);
        walk(va_of(0, 2, 0), 1'b1, 1'b0, 0);
        chk("R3 inner absent cause", {30'd0, got_cause}, 32'd1);
        chk("R5 absent no write", 32'(wr_cnt - w0), 32'd0);
        chk("R7 fault nocache", {31'd0, got_nc}, 32'd0);
    endtask

    task automatic t_protection();
        int w0 = wr_cnt;
        walk(va_of(0, 1, 0), 1'b1, 1'b0, 0);
        chk("R4 write ro cause", {30'd0, got_cause}, 32'd2);
        chk("R4 fault flag", {31'd0, got_fault}, 32'd1);
        chk("R2 fault paddr zero", got_paddr, 32'd0);
        walk(va_of(0, 6, 0), 1'b1, 1'b0, 0);
        chk("R4 write ro unreferenced", {30'd0, got_cause}, 32'd2);
        chk("R5 entry kept", mem[12'd2054], 32'h0444_4005);
        walk(va_of(0, 3, 0), 1'b0, 1'b1, 0);
        chk("R4 user to supervisor", {30'd0, got_cause}, 32'd2);
        chk("R5 prot no write", 32'(wr_cnt - w0), 32'd0);
        chk("R5 supervisor entry kept", mem[12'd2051], 32'h5555_5023);
    endtask

    task automatic t_nocache();
        int w0 = wr_cnt;
        walk(va_of(0, 3, 12'h123), 1'b0, 1'b0, 2);
        chk("R7 nocache out", {31'd0, got_nc}, 32'd1);
        chk("R2 supervisor paddr", got_paddr, 32'h5555_5123);
        chk("R6 ref write", 32'(wr_cnt - w0), 32'd1);
        chk("R6 ref only", mem[12'd2051], 32'h5555_502B);
    endtask

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = 32'd0;
        mem[1024] = 32'h0000_2001;
        mem[1025] = 32'h0000_3001;
        mem[1026] = 32'h0000_3000;
        mem[2048] = 32'hABCD_E007;
        mem[2049] = 32'h1234_500D;
        mem[2050] = 32'h9999_9006;
        mem[2051] = 32'h5555_5023;
        mem[2052] = 32'h0F0F_000F;
        mem[2054] = 32'h0444_4005;
        mem[3072 + 5] = 32'h7777_701F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_read_no_change();
        t_write_dirty();
        t_absent();
        t_protection();
        t_nocache();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule